// File: doc/BRIEF.md
# Double-Data-Rate Separate-IO Burst SRAM Model

This block is a synthesizable behaviour model of a pipelined synchronous static memory with one shared address bus, a dedicated write-data bus and a dedicated read-data bus. Every access moves two words as a sequential pair: beat 0 first, then beat 1. Both beats travel on one clock period, one on the rising edge of the K clock and one on its falling edge, so read and write data never share wires and the bus never needs to turn around.

A controller issues one operation per rising edge, either a read or a write. Write data follows the address by one cycle. Read data comes back one and a half cycles after the address when the delay-locked clocking mode is active, or one cycle after it in the legacy mode that is used with the DLL off. A read that hits a write still waiting for its array commit receives the new data. The output bus carries an explicit enable in place of a high-impedance state, and a strobe marks the first beat of each returned pair.

Top module: `ddr_sio_sram`

## Requirements
- R1: Each address holds a pair of words. A read returns beat 0 then beat 1 of that pair in consecutive half-cycles, and a write fills beat 0 and beat 1 in the same order.
- R2: An operation is issued when `ld_ni` is low at a rising edge of `clk_i`. `rw_i` high selects a read and low selects a write. A high `ld_ni` issues nothing, and at most one operation is issued per rising edge.
- R3: For a write issued at rising edge n, beat 0 is sampled from `d_i` at rising edge n+1 and beat 1 at the falling edge that follows it. `d_i` and `bw_ni` are ignored at every other time.
- R4: `bw_ni` is an active-low lane mask sampled with each write beat. Bit l covers data bits [9l+8:9l]. A lane whose bit is high keeps its stored value for that beat.
- R5: With `dll_off_i` low, a read issued at rising edge n drives beat 0 after the falling edge that follows edge n+1, and beat 1 after rising edge n+2.
- R6: With `dll_off_i` high, a read issued at rising edge n drives beat 0 after rising edge n+1 and beat 1 after the falling edge that follows it. `dll_off_i` changes only while reset is asserted.
- R7: A read issued right after a write to the same address returns the new lanes of that write, even though the array commit happens on the same edge the read is fetched.
- R8: Whenever no read beat is being driven, `q_oe_o` is low and `q_o` is zero. After the last beat of a read, the outputs are disabled in the next half-cycle unless another read beat follows.
- R9: `q_start_o` is high exactly while beat 0 of a read is on `q_o`.
- R10: Reads and writes may be issued on every rising edge with no idle cycles between them, in any mix, and each returns correct data.
- R11: While `rst_ni` is low, `q_oe_o`, `q_start_o` and `q_o` are zero. Every stored word reads as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | K clock; both edges carry data beats |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dll_off_i | input | 1 | 1 selects the one-cycle legacy read latency |
| ld_ni | input | 1 | Operation strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW (4) | Word-pair address |
| d_i | input | LANES*LANE_W (18) | Write data, one beat per clock edge |
| bw_ni | input | LANES (2) | Active-low write lane mask |
| q_o | output | LANES*LANE_W (18) | Read data, zero when disabled |
| q_oe_o | output | 1 | Read data valid / output enable |
| q_start_o | output | 1 | Marks the first beat of a read pair |

## Verification
A stale or missing forward appears on beat 0 of the very next read, and the bench deliberately places a read right after a write to the same address. An off-by-one in either latency pipeline moves `q_oe_o` by a half-cycle, so the first half-cycle of every read shows it in each mode. A swapped beat or a wrong lane mask corrupts only one half-cycle's word, so the bench compares data at every half-cycle against a reference array. Stray enables after an idle cycle show up in the half-cycle after a burst, because the bench expects zero data there.

// File: rtl/ddr_sio_pkg.sv
`timescale 1ns/1ps
package ddr_sio_pkg;
  localparam int unsigned DEF_AW     = 4;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 9;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dir_e;
endpackage

// File: rtl/ddr_sio_cmd.sv
`timescale 1ns/1ps
module ddr_sio_cmd
  import ddr_sio_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_ni,
  input  logic                    rw_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic [LANES-1:0]        bw_ni,
  output logic                    s1_v_o,
  output logic                    s1_rd_o,
  output logic [AW-1:0]           s1_addr_o,
  output logic                    w_v_o,
  output logic [AW-1:0]           w_addr_o,
  output logic [LANES*LANE_W-1:0] w_d0_o,
  output logic [LANES*LANE_W-1:0] w_d1_o,
  output logic [LANES-1:0]        w_m0_o,
  output logic [LANES-1:0]        w_m1_o
);
  localparam int unsigned W = LANES * LANE_W;

  dir_e    s1_dir;
  logic    s1_wr;

  assign s1_wr   = s1_v_o && (s1_dir == DIR_WR);
  assign s1_rd_o = (s1_dir == DIR_RD);

  // address/command stage, then beat 0 of a write one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_o    <= 1'b0;
      s1_dir    <= DIR_WR;
      s1_addr_o <= '0;
      w_v_o     <= 1'b0;
      w_addr_o  <= '0;
      w_d0_o    <= '0;
      w_m0_o    <= '1;
    end else begin
      s1_v_o    <= !ld_ni;
      s1_dir    <= dir_e'(rw_i);
      s1_addr_o <= addr_i;
      w_v_o     <= s1_wr;
      if (s1_wr) begin
        w_addr_o <= s1_addr_o;
        w_d0_o   <= d_i;
        w_m0_o   <= bw_ni;
      end
    end
  end

  // beat 1 of a write on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_d1_o <= {W{1'b0}};
      w_m1_o <= '1;
    end else if (w_v_o) begin
      w_d1_o <= d_i;
      w_m1_o <= bw_ni;
    end
  end

  p_wr_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_wr |=> (w_v_o && (w_addr_o == $past(s1_addr_o))));
endmodule

// File: rtl/ddr_sio_array.sv
`timescale 1ns/1ps
module ddr_sio_array
  import ddr_sio_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    s1_v_i,
  input  logic                    s1_rd_i,
  input  logic [AW-1:0]           s1_addr_i,
  input  logic                    w_v_i,
  input  logic [AW-1:0]           w_addr_i,
  input  logic [LANES*LANE_W-1:0] w_d0_i,
  input  logic [LANES*LANE_W-1:0] w_d1_i,
  input  logic [LANES-1:0]        w_m0_i,
  input  logic [LANES-1:0]        w_m1_i,
  output logic                    f_v_o,
  output logic [LANES*LANE_W-1:0] f0_o,
  output logic [LANES*LANE_W-1:0] f1_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic fwd;

  // pending write commits on the same edge the read is fetched
  assign fwd   = w_v_i && (w_addr_i == s1_addr_i);
  assign f_v_o = s1_v_i && s1_rd_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned LO = l * LANE_W;
    logic [LANE_W-1:0] m0 [DEPTH];
    logic [LANE_W-1:0] m1 [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) begin
          m0[i] <= '0;
          m1[i] <= '0;
        end
      end else if (w_v_i) begin
        if (!w_m0_i[l]) m0[w_addr_i] <= w_d0_i[LO +: LANE_W];
        if (!w_m1_i[l]) m1[w_addr_i] <= w_d1_i[LO +: LANE_W];
      end
    end

    assign f0_o[LO +: LANE_W] = (fwd && !w_m0_i[l]) ? w_d0_i[LO +: LANE_W] : m0[s1_addr_i];
    assign f1_o[LO +: LANE_W] = (fwd && !w_m1_i[l]) ? w_d1_i[LO +: LANE_W] : m1[s1_addr_i];
  end
endmodule

// File: rtl/ddr_sio_out.sv
`timescale 1ns/1ps
module ddr_sio_out
  import ddr_sio_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dll_off_i,
  input  logic                    f_v_i,
  input  logic [LANES*LANE_W-1:0] f0_i,
  input  logic [LANES*LANE_W-1:0] f1_i,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_oe_o,
  output logic                    q_start_o
);
  localparam int unsigned W = LANES * LANE_W;

  logic         h_v;
  logic [W-1:0] h0, h1;
  logic         p_v, p_first, n_v, n_first;
  logic [W-1:0] p_d, n_d;

  // rising-edge half: hold the fetched pair and drive the rise beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_v     <= 1'b0;
      h0      <= '0;
      h1      <= '0;
      p_v     <= 1'b0;
      p_first <= 1'b0;
      p_d     <= '0;
    end else begin
      h_v <= f_v_i;
      h0  <= f0_i;
      h1  <= f1_i;
      if (dll_off_i) begin
        p_v     <= f_v_i;
        p_first <= f_v_i;
        p_d     <= f_v_i ? f0_i : '0;
      end else begin
        p_v     <= h_v;
        p_first <= 1'b0;
        p_d     <= h_v ? h1 : '0;
      end
    end
  end

  // falling-edge half
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_v     <= 1'b0;
      n_first <= 1'b0;
      n_d     <= '0;
    end else begin
      n_v     <= h_v;
      n_first <= h_v && !dll_off_i;
      n_d     <= h_v ? (dll_off_i ? h1 : h0) : '0;
    end
  end

  assign q_o       = clk_i ? p_d     : n_d;
  assign q_oe_o    = clk_i ? p_v     : n_v;
  assign q_start_o = clk_i ? p_first : n_first;

  p_dll_on_beat1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dll_off_i && f_v_i) |=> (!p_first && (h_v == 1'b1)));
  p_dll_off_beat0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dll_off_i && f_v_i) |=> (p_v && p_first && (p_d == $past(f0_i))));
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> (q_o == '0));
  p_start_in_burst_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    q_start_o |-> q_oe_o);
endmodule

// File: rtl/ddr_sio_sram.sv
`timescale 1ns/1ps
module ddr_sio_sram
  import ddr_sio_pkg::*;
#(
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dll_off_i,
  input  logic                    ld_ni,
  input  logic                    rw_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic [LANES-1:0]        bw_ni,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_oe_o,
  output logic                    q_start_o
);
  localparam int unsigned W = LANES * LANE_W;

  logic          s1_v, s1_rd, w_v, f_v;
  logic [AW-1:0] s1_addr, w_addr;
  logic [W-1:0]  w_d0, w_d1, f0, f1;
  logic [LANES-1:0] w_m0, w_m1;

  ddr_sio_cmd #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i, .d_i, .bw_ni,
    .s1_v_o(s1_v), .s1_rd_o(s1_rd), .s1_addr_o(s1_addr),
    .w_v_o(w_v), .w_addr_o(w_addr), .w_d0_o(w_d0), .w_d1_o(w_d1),
    .w_m0_o(w_m0), .w_m1_o(w_m1)
  );

  ddr_sio_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni,
    .s1_v_i(s1_v), .s1_rd_i(s1_rd), .s1_addr_i(s1_addr),
    .w_v_i(w_v), .w_addr_i(w_addr), .w_d0_i(w_d0), .w_d1_i(w_d1),
    .w_m0_i(w_m0), .w_m1_i(w_m1),
    .f_v_o(f_v), .f0_o(f0), .f1_o(f1)
  );

  ddr_sio_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk_i, .rst_ni, .dll_off_i,
    .f_v_i(f_v), .f0_i(f0), .f1_i(f1),
    .q_o, .q_oe_o, .q_start_o
  );
endmodule

// File: tb/ddr_sio_sram_tb.sv
`timescale 1ns/1ps
module ddr_sio_sram_tb_top;
  localparam int AW = 4, LANES = 2, LANE_W = 9, W = 18, DEPTH = 16;
  localparam int NCYC = 106, NSLOT = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, dll_off, ld_n, rw;
  logic [AW-1:0] addr;
  logic [W-1:0]  din, q;
  logic [LANES-1:0] bw_n;
  logic q_oe, q_start;

  ddr_sio_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dll_off_i(dll_off), .ld_ni(ld_n), .rw_i(rw),
    .addr_i(addr), .d_i(din), .bw_ni(bw_n),
    .q_o(q), .q_oe_o(q_oe), .q_start_o(q_start)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int            op_k [NCYC];  // 0 idle, 1 write, 2 read
  logic [AW-1:0] op_a [NCYC];
  logic [W-1:0]  op_d0 [NCYC], op_d1 [NCYC];
  logic [LANES-1:0] op_m0 [NCYC], op_m1 [NCYC];

  logic [W-1:0] ref0 [DEPTH], ref1 [DEPTH];
  bit           part [DEPTH];
  bit           exp_v [NSLOT], exp_f [NSLOT];
  logic [W-1:0] exp_d [NSLOT];
  int           exp_t [NSLOT];

  function automatic string tag_s(int t);
    case (t)
      1: return "R4";
      2: return "R7";
      5: return "R11";
      default: return "R1 R2 R3 R10";
    endcase
  endfunction

  task automatic build_ops();
    logic [15:0] lf = 16'hACE1;
    for (int c = 0; c < NCYC; c++) begin
      op_d0[c] = W'((c * 1237 + 11) ^ 'h2A5A5);
      op_d1[c] = W'((c * 4099 + 3) ^ 'h15A5A);
      op_m0[c] = '0; op_m1[c] = '0; op_a[c] = '0; op_k[c] = 0;
      if (c < 2) begin
        op_k[c] = 2; op_a[c] = (c == 0) ? 4'd3 : 4'd9;
      end else if (c < 18) begin
        op_k[c] = 1; op_a[c] = AW'(c - 2);
      end else if (c < 34) begin
        op_k[c] = 2; op_a[c] = AW'(c - 18);
      end else if (c < 66) begin
        int j = c - 34;
        case (j % 4)
          0: begin op_k[c] = 1; op_a[c] = AW'(j / 4);
                   op_m0[c] = LANES'((j / 4) % 4); op_m1[c] = LANES'((j / 4 + 1) % 4); end
          1: begin op_k[c] = 2; op_a[c] = AW'(j / 4); end
          2: op_k[c] = 0;
          default: begin op_k[c] = 2; op_a[c] = AW'((j / 4 + 3) % 16); end
        endcase
      end else if (c < 98) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        op_k[c]  = (lf[1:0] == 2'd0) ? 1 : (lf[1:0] == 2'd3) ? 0 : 2;
        op_a[c]  = lf[7:4];
        op_m0[c] = lf[9:8];
        op_m1[c] = lf[11:10];
      end
    end
  endtask

  task automatic fail(string t, string what, int s, logic [W-1:0] got, logic [W-1:0] exp);
    n_bad++;
    $display("FAIL %s %s slot %0d: got %h expected %h", t, what, s, got, exp);
  endtask

  task automatic check_slot(int s);
    string ot = exp_v[s] ? (dll_off ? "R6" : "R5") : "R8";
    n_cmp++;
    if (q_oe !== exp_v[s]) fail(ot, "enable", s, W'(q_oe), W'(exp_v[s]));
    n_cmp++;
    if (q !== exp_d[s]) fail(exp_v[s] ? tag_s(exp_t[s]) : "R8", "data", s, q, exp_d[s]);
    n_cmp++;
    if (q_start !== exp_f[s]) fail("R9", "start", s, W'(q_start), W'(exp_f[s]));
  endtask

  task automatic apply_write(int c);
    int a = int'(op_a[c]);
    for (int l = 0; l < LANES; l++) begin
      if (!op_m0[c][l]) ref0[a][l*LANE_W +: LANE_W] = op_d0[c][l*LANE_W +: LANE_W];
      if (!op_m1[c][l]) ref1[a][l*LANE_W +: LANE_W] = op_d1[c][l*LANE_W +: LANE_W];
    end
    part[a] = |(op_m0[c] | op_m1[c]);
  endtask

  task automatic plan_read(int c);
    int a = int'(op_a[c]);
    int b0 = dll_off ? 2 * c + 2 : 2 * c + 3;
    int t;
    if (c < 2) t = 5;                                             // R11 reset array
    else if (c > 0 && op_k[c-1] == 1 && op_a[c-1] == op_a[c]) t = 2;  // R7
    else t = part[a] ? 1 : 0;                                     // R4 or R1
    exp_v[b0] = 1; exp_f[b0] = 1; exp_d[b0] = ref0[a]; exp_t[b0] = t;
    exp_v[b0+1] = 1; exp_f[b0+1] = 0; exp_d[b0+1] = ref1[a]; exp_t[b0+1] = t;
  endtask

  task automatic run_pass(bit mode);
    rst_n = 0; dll_off = mode; ld_n = 1; rw = 0; addr = '0; din = '0; bw_n = '1;
    for (int i = 0; i < DEPTH; i++) begin ref0[i] = '0; ref1[i] = '0; part[i] = 0; end
    for (int s = 0; s < NSLOT; s++) begin exp_v[s] = 0; exp_f[s] = 0; exp_d[s] = '0; exp_t[s] = 0; end
    repeat (2) @(negedge clk);
    #1;
    n_cmp++;
    if (q_oe !== 1'b0 || q_start !== 1'b0 || q !== '0)
      fail("R11", "reset outputs", -1, q, '0);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NCYC; c++) begin
      #1.5;
      ld_n = (op_k[c] == 0);
      rw   = (op_k[c] == 2);
      addr = op_a[c];
      if (op_k[c] == 1) apply_write(c);
      if (op_k[c] == 2) plan_read(c);
      if (c > 0 && op_k[c-1] == 1) begin din = op_d0[c-1]; bw_n = op_m0[c-1]; end
      else begin din = op_d1[c]; bw_n = '0; end  // R3 noise while no write beat is due
      @(posedge clk);
      #1 check_slot(2 * c);
      #1.5;
      if (c > 0 && op_k[c-1] == 1) begin din = op_d1[c-1]; bw_n = op_m1[c-1]; end
      else begin din = op_d0[c]; bw_n = '0; end
      @(negedge clk);
      #1 check_slot(2 * c + 1);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    build_ops();
    run_pass(1'b0);  // R5 path
    run_pass(1'b1);  // R6 path
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule